// File: doc/BRIEF.md
# Pixel Hit Time-Stamp Capture

This block holds the digital side of a single detector pixel together with the time base that all pixels share. A binary count advances whenever the time-stamp step input is high at a clock edge. It is driven out in Gray code, so that every pixel sees at most one bit change per step. One count stands for 3.9 microseconds of beam time. The count is 8 bits wide and wraps from 255 back to 0.

While the chip is acquiring, a rising edge on the pixel's hit input makes the pixel store the current Gray count and set its hit flag. The hit input is asynchronous and comes from the discriminator. Only one hit is kept. Later pulses are dropped until the stored hit has been read out. In report mode, the stored flag and stamp are shown to the readout logic. When the readout selects the pixel, the pixel raises a release request toward the analog side. A done strobe given while the pixel is selected clears the flag and the stamp.

Top module: `pix_stamp_top`

## Requirements
- R1: Directly after reset, gray_o, hit_flag_o, stamp_o and release_o are all 0.
- R2: At every clock edge where ts_adv_i is 1, the internal binary count b goes up by one, wrapping from 255 to 0. gray_o then shows b ^ (b >> 1). At an edge where ts_adv_i is 0, gray_o keeps its value.
- R3: Between two consecutive clock edges, at most one bit of gray_o changes.
- R4: In acquire mode (mode_report_i = 0), with no hit stored, a rising edge of hit_i is captured. If edge k is the first clock edge that samples hit_i high, the hit flag is set at edge k+2. The stored stamp is the gray_o value present just before edge k+2.
- R5: While a hit is stored, further rising edges of hit_i leave the flag and the stamp unchanged.
- R6: A rising edge of hit_i that would be captured while mode_report_i = 1 is dropped. It is not captured later, even if hit_i is still high when the mode returns to acquire.
- R7: hit_flag_o equals the stored flag when mode_report_i = 1, and is 0 otherwise. stamp_o equals the stored stamp when mode_report_i = 1 and the flag is set, and is 0 otherwise.
- R8: release_o is 1 exactly when sel_i = 1, mode_report_i = 1 and a hit is stored.
- R9: A clock edge with sel_i = 1, done_i = 1 and mode_report_i = 1 clears the flag and the stamp. done_i without sel_i, or in acquire mode, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ts_adv_i | input | 1 | Advance the time base by one count |
| mode_report_i | input | 1 | 0 = acquire, 1 = report |
| hit_i | input | 1 | Asynchronous hit pulse from the discriminator |
| sel_i | input | 1 | Readout has selected this pixel |
| done_i | input | 1 | Readout of the selected pixel is finished |
| gray_o | output | 8 | Broadcast Gray-coded time stamp |
| hit_flag_o | output | 1 | Stored hit flag, visible in report mode |
| stamp_o | output | 8 | Stored time stamp, visible in report mode |
| release_o | output | 1 | Release-data request to the analog side |

## Verification
The bench targets the following corner cases:
- A hit held high across a switch from report to acquire. A level-sensitive capture would store it.
- A second pulse arriving on an already stored hit. A design that overwrites would change the stamp.
- The count step from 255 to 0. A wrong Gray conversion shows up here as a jump of several bits.
- A done strobe without a select. A design that ignores the select would lose hits that have not been read.

Hit timing is checked cycle by cycle against the two-edge capture latency. A design with a different synchronizer depth would therefore store a neighbouring stamp.

// File: rtl/pix_stamp_pkg.sv
package pix_stamp_pkg;
  localparam int unsigned TS_W = 8;
  typedef logic [TS_W-1:0] ts_t;

  function automatic ts_t to_gray(ts_t b);
    return b ^ (b >> 1);
  endfunction
endpackage

// File: rtl/gray_ts_counter.sv
module gray_ts_counter
  import pix_stamp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  output ts_t  gray_o
);
  ts_t bin_q, bin_nxt, gray_q;

  assign bin_nxt = bin_q + ts_t'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else if (adv_i) begin
      bin_q  <= bin_nxt;
      gray_q <= to_gray(bin_nxt);
    end
  end

  assign gray_o = gray_q;
endmodule

// File: rtl/hit_edge_sync.sv
module hit_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  output logic rise_o
);
  localparam int unsigned DEPTH = STAGES + 1;
  logic [DEPTH-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[DEPTH-2:0], hit_i};
  end

  // edge seen after STAGES synchronizer flops
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/pix_hit_store.sv
module pix_hit_store
  import pix_stamp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic report_i,
  input  logic clear_i,
  input  ts_t  gray_i,
  output logic flag_o,
  output ts_t  stamp_o
);
  logic flag_q;
  ts_t  stamp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      stamp_q <= '0;
    end else if (clear_i) begin
      flag_q  <= 1'b0;
      stamp_q <= '0;
    end else if (rise_i && !report_i && !flag_q) begin
      flag_q  <= 1'b1;
      stamp_q <= gray_i;
    end
  end

  assign flag_o  = flag_q;
  assign stamp_o = stamp_q;
endmodule

// File: rtl/pix_stamp_top.sv
module pix_stamp_top
  import pix_stamp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ts_adv_i,
  input  logic            mode_report_i,
  input  logic            hit_i,
  input  logic            sel_i,
  input  logic            done_i,
  output logic [TS_W-1:0] gray_o,
  output logic            hit_flag_o,
  output logic [TS_W-1:0] stamp_o,
  output logic            release_o
);
  ts_t  gray_w;
  ts_t  stamp_held;
  logic hit_stored;
  logic hit_rise;
  logic clear_w;

  gray_ts_counter u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (ts_adv_i),
    .gray_o (gray_w)
  );

  hit_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit_i),
    .rise_o (hit_rise)
  );

  assign clear_w = sel_i & done_i & mode_report_i;

  pix_hit_store u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rise_i   (hit_rise),
    .report_i (mode_report_i),
    .clear_i  (clear_w),
    .gray_i   (gray_w),
    .flag_o   (hit_stored),
    .stamp_o  (stamp_held)
  );

  assign gray_o     = gray_w;
  assign hit_flag_o = hit_stored & mode_report_i;
  assign stamp_o    = (hit_stored && mode_report_i) ? stamp_held : '0;
  assign release_o  = sel_i & mode_report_i & hit_stored;
endmodule

// File: rtl/pix_stamp_chk.sv
module pix_stamp_chk
  import pix_stamp_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic ts_adv_i,
  input logic mode_report_i,
  input logic sel_i,
  input logic done_i,
  input ts_t  gray_o,
  input logic hit_flag_o,
  input ts_t  stamp_o,
  input logic release_o,
  input logic flag_q,
  input ts_t  stamp_q
);
  localparam ts_t GRAY_TOP = ts_t'(1) << (TS_W - 1);

  // R2
  gray_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ts_adv_i |=> $stable(gray_o));
  // R2
  gray_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ts_adv_i && gray_o == GRAY_TOP) |=> gray_o == '0);
  // R3
  gray_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $countones(gray_o ^ $past(gray_o)) <= 1);
  // R5
  hold_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !(sel_i && done_i && mode_report_i)) |=> (flag_q && $stable(stamp_q)));
  // R6
  report_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_report_i && !flag_q) |=> !flag_q);
  // R7
  acq_hide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_report_i |-> (!hit_flag_o && stamp_o == '0));
  // R8
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_o |-> (hit_flag_o && sel_i));
  // R9
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && done_i && mode_report_i) |=> (!flag_q && stamp_q == '0));
endmodule

bind pix_stamp_top pix_stamp_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ts_adv_i      (ts_adv_i),
  .mode_report_i (mode_report_i),
  .sel_i         (sel_i),
  .done_i        (done_i),
  .gray_o        (gray_o),
  .hit_flag_o    (hit_flag_o),
  .stamp_o       (stamp_o),
  .release_o     (release_o),
  .flag_q        (hit_stored),
  .stamp_q       (stamp_held)
);

// File: tb/pix_stamp_top_tb_top.sv
module pix_stamp_top_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ts_adv_i = 1'b0, mode_report_i = 1'b0, hit_i = 1'b0;
  logic       sel_i = 1'b0, done_i = 1'b0;
  logic [7:0] gray_o, stamp_o;
  logic       hit_flag_o, release_o;

  int unsigned n_chk = 0, n_err = 0;

  // reference model state
  logic [7:0] m_cnt = 0, m_gray = 0, m_stamp = 0;
  logic       m_flag = 0, s1 = 0, s2 = 0, s3 = 0;

  always #2.5 clk_i = ~clk_i;

  pix_stamp_top dut_i (.*);

  function automatic logic [7:0] gray_of(logic [7:0] b);
    return b ^ (b >> 1);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // drive at negedge, model at posedge, compare just after
  task automatic tick(logic adv, logic rep, logic hit, logic sel, logic done);
    logic rise;
    @(negedge clk_i);
    ts_adv_i = adv; mode_report_i = rep; hit_i = hit; sel_i = sel; done_i = done;
    @(posedge clk_i);
    rise = s2 & ~s3;  // R4: two sync edges then edge detect
    if (sel && done && rep) begin m_flag = 0; m_stamp = 0; end
    else if (rise && !rep && !m_flag) begin m_flag = 1; m_stamp = m_gray; end
    s3 = s2; s2 = s1; s1 = hit;
    if (adv) begin m_cnt = m_cnt + 8'd1; m_gray = gray_of(m_cnt); end
    #1;
    check("R2 gray", gray_o, m_gray);
    check("R7 flag", hit_flag_o, m_flag & rep);
    check("R7 stamp", stamp_o, (m_flag && rep) ? m_stamp : 8'h0);
    check("R8 release", release_o, sel & rep & m_flag);
  endtask

  initial begin
    #(5.0 * 200000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] prev_g;
    logic [7:0] keep;
    void'($urandom(32'd1234));
    #1;
    // R1 reset values
    check("R1 gray", gray_o, 0);
    check("R1 flag", hit_flag_o, 0);
    check("R1 stamp", stamp_o, 0);
    check("R1 release", release_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;

    // R2 count up a few steps
    for (int i = 0; i < 5; i++) tick(1, 0, 0, 0, 0);
    check("R2 five steps", gray_o, gray_of(8'd5));

    // R4 directed capture, time base frozen
    tick(0, 0, 1, 0, 0);
    tick(0, 0, 1, 0, 0);
    tick(0, 0, 1, 0, 0);
    tick(0, 1, 0, 0, 0);
    check("R4 flag set", hit_flag_o, 1);
    check("R4 stamp", stamp_o, gray_of(8'd5));

    // R5 second hit ignored
    for (int i = 0; i < 3; i++) tick(1, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) tick(1, 0, 1, 0, 0);
    tick(0, 1, 0, 0, 0);
    check("R5 stamp kept", stamp_o, gray_of(8'd5));

    // R9 done without select ignored, then real clear
    tick(0, 1, 0, 0, 1);
    check("R9 no sel", hit_flag_o, 1);
    tick(0, 0, 0, 1, 1);
    tick(0, 1, 0, 0, 0);
    check("R9 acquire done", hit_flag_o, 1);
    tick(0, 1, 0, 1, 0);
    check("R8 release up", release_o, 1);
    tick(0, 1, 0, 1, 1);
    check("R9 cleared flag", hit_flag_o, 0);
    check("R9 cleared stamp", stamp_o, 0);
    check("R8 release down", release_o, 0);

    // R6 hit rising in report, held into acquire
    for (int i = 0; i < 4; i++) tick(1, 1, 1, 0, 0);
    for (int i = 0; i < 4; i++) tick(1, 0, 1, 0, 0);
    tick(0, 1, 0, 0, 0);
    check("R6 dropped", hit_flag_o, 0);

    // R2/R3 wrap through 255->0
    keep = gray_o;
    for (int i = 0; i < 300; i++) begin
      prev_g = gray_o;
      tick(1, 0, 0, 0, 0);
      if ($countones(prev_g ^ gray_o) > 1) check("R3 one bit", prev_g ^ gray_o, 0);
      else n_chk++;
      if (prev_g == 8'h80) check("R2 wrap", gray_o, 0);
    end
    check("R2 after wrap", gray_o, gray_of(m_cnt));

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic rep, hit;
      rep = ($urandom % 8) < 3;
      hit = ($urandom % 4) == 0;
      tick(($urandom % 2) == 1, rep, hit, ($urandom % 3) == 0, ($urandom % 4) == 0);
    end

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule